// File: doc/BRIEF.md
# Entropy Tap Select and Capture

This block takes a wide vector of single-bit entropy cells and turns it into a stream of captured random bytes. Once per sample period it either folds every cell into one bit by exclusive-OR, or routes a single chosen cell through. The chosen bit is held in a register. A fast board clock is divided down to the sample rate, so one clock drives the whole block and each sample is marked by a one-cycle strobe.

A host sets the source through a small command port. The command gives a mode (folded or single cell) and a cell index, which lets each cell be studied on its own before the folded output is trusted. Captured bits are packed into bytes, first bit in the most significant position, and the bytes are queued in a FIFO. A sticky flag records any bit that arrives while the FIFO is full.

Top module: `entropy_tap_capture`

## Requirements
- R1: After a synchronous reset, `fifo_empty_o`=1, `fifo_full_o`=0, `overflow_o`=0, `sample_valid_o`=0 and `rd_data_o`=0. The source is folded mode with index 0.
- R2: `sample_valid_o` is high for exactly one clock cycle in every DIV_RATIO cycles. The default is 20, which gives 2.5 MHz from 50 MHz.
- R3: In folded mode (mode bit 0), the bit on `sample_bit_o` during the strobe is the XOR of all `cells_i` bits as they stood at the capturing clock edge.
- R4: In single-cell mode (mode bit 1), the bit is `cells_i[index]` at the capturing edge. This holds for both index 0 and index N_CELLS-1.
- R5: A clock edge with `cmd_valid_i` high stores the mode and index as pending. The first sample captured at a later edge uses them. A sample captured on the same edge as the write still uses the previous setting. When several writes fall between two samples, only the last one counts.
- R6: The bits are packed into bytes. The first bit of a byte goes to bit 7, the eighth bit goes to bit 0, and each full byte enters the FIFO.
- R7: If the mode or index used by a sample differs from the one used by the previous sample, the partial byte is discarded. That sample becomes bit 7 of a new byte. Writing back the same setting does not discard anything.
- R8: When `rd_en_i` is high and the FIFO is not empty, `rd_data_o` shows the oldest byte in the next cycle, and bytes come out in arrival order. A read while empty leaves `rd_data_o` unchanged.
- R9: `fifo_full_o` rises when FIFO_DEPTH bytes are held. A byte completed while full is dropped, and the bytes already held are kept intact.
- R10: A sample that reaches the packer while the FIFO is full sets `overflow_o`. The flag stays set until reset.
- R11: `fifo_full_o` and `fifo_empty_o` are never high together.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Fast board clock |
| rst | input | 1 | Synchronous active-high reset |
| cells_i | input | N_CELLS | Entropy cell outputs |
| cmd_valid_i | input | 1 | Command write strobe |
| cmd_mode_i | input | 1 | 0 = folded XOR, 1 = single cell |
| cmd_index_i | input | $clog2(N_CELLS) | Cell index for single-cell mode |
| rd_en_i | input | 1 | Pop one byte from the FIFO |
| sample_bit_o | output | 1 | Registered captured bit |
| sample_valid_o | output | 1 | One-cycle strobe per sample |
| rd_data_o | output | BYTE_W | Registered FIFO read data |
| fifo_empty_o | output | 1 | FIFO holds no byte |
| fifo_full_o | output | 1 | FIFO holds FIFO_DEPTH bytes |
| overflow_o | output | 1 | Sticky full-FIFO loss flag |

## Verification
The bench builds the block with N_CELLS=16, DIV_RATIO=4 and FIFO_DEPTH=4. With a 16-cell vector, the last index is a real boundary, and driving all cells high folds to a known zero. A sample every fourth cycle means hundreds of samples and dozens of packed bytes fit in a short run. A command write can be lined up exactly with a capturing edge. Four FIFO entries fill after thirty-two samples, so the full, drop and sticky-overflow behaviour is reached quickly, and the block is also drained after it has overflowed.

// File: rtl/etc_pkg.sv
package etc_pkg;
  typedef enum logic {
    SRC_FOLD = 1'b0,
    SRC_CELL = 1'b1
  } src_e;
endpackage

// File: rtl/etc_clk_div.sv
module etc_clk_div #(
  parameter int DIV_RATIO = 20
) (
  input  logic clk,
  input  logic rst,
  output logic tick_o
);
  generate
    if (DIV_RATIO <= 1) begin : g_passthru
      always_ff @(posedge clk) begin
        if (rst) tick_o <= 1'b0;
        else     tick_o <= 1'b1;
      end
    end else begin : g_count
      localparam int CW = $clog2(DIV_RATIO);
      localparam logic [CW-1:0] LAST = CW'(DIV_RATIO - 1);
      logic [CW-1:0] cnt_q;
      always_ff @(posedge clk) begin
        if (rst) begin
          cnt_q  <= '0;
          tick_o <= 1'b0;
        end else begin
          tick_o <= (cnt_q == LAST);
          cnt_q  <= (cnt_q == LAST) ? '0 : cnt_q + 1'b1;
        end
      end
    end
  endgenerate
endmodule

// File: rtl/etc_tap_select.sv
module etc_tap_select
  import etc_pkg::*;
#(
  parameter  int N_CELLS = 256,
  localparam int IDX_W   = $clog2(N_CELLS)
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               tick_i,
  input  logic [N_CELLS-1:0] cells_i,
  input  logic               cmd_valid_i,
  input  logic               cmd_mode_i,
  input  logic [IDX_W-1:0]   cmd_index_i,
  output logic               bit_o,
  output logic               valid_o,
  output logic               restart_o
);
  src_e             pend_src, act_src;
  logic [IDX_W-1:0] pend_idx, act_idx;
  logic             fold_bit, cell_bit, chosen_bit, cfg_changed;

  // Fold of every cell and the per-cell route
  assign fold_bit    = ^cells_i;
  assign cell_bit    = cells_i[pend_idx];
  assign chosen_bit  = (pend_src == SRC_CELL) ? cell_bit : fold_bit;
  assign cfg_changed = (pend_src != act_src) || (pend_idx != act_idx);

  always_ff @(posedge clk) begin
    if (rst) begin
      pend_src  <= SRC_FOLD;
      pend_idx  <= '0;
      act_src   <= SRC_FOLD;
      act_idx   <= '0;
      bit_o     <= 1'b0;
      valid_o   <= 1'b0;
      restart_o <= 1'b0;
    end else begin
      if (cmd_valid_i) begin
        pend_src <= src_e'(cmd_mode_i);
        pend_idx <= cmd_index_i;
      end
      valid_o   <= tick_i;
      restart_o <= tick_i && cfg_changed;
      if (tick_i) begin
        bit_o   <= chosen_bit;
        act_src <= pend_src;
        act_idx <= pend_idx;
      end
    end
  end
endmodule

// File: rtl/etc_byte_packer.sv
module etc_byte_packer #(
  parameter int BYTE_W = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              bit_i,
  input  logic              valid_i,
  input  logic              restart_i,
  output logic [BYTE_W-1:0] byte_o,
  output logic              push_o
);
  localparam int CW = $clog2(BYTE_W);
  localparam logic [CW-1:0] LAST = CW'(BYTE_W - 1);

  logic [BYTE_W-1:0] sr_q, base_sr, next_sr;
  logic [CW-1:0]     cnt_q, base_cnt;

  always_comb begin
    base_sr  = restart_i ? '0 : sr_q;
    base_cnt = restart_i ? '0 : cnt_q;
    next_sr  = {base_sr[BYTE_W-2:0], bit_i};
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      sr_q   <= '0;
      cnt_q  <= '0;
      byte_o <= '0;
      push_o <= 1'b0;
    end else begin
      push_o <= 1'b0;
      if (valid_i) begin
        sr_q <= next_sr;
        if (base_cnt == LAST) begin
          cnt_q  <= '0;
          byte_o <= next_sr;
          push_o <= 1'b1;
        end else begin
          cnt_q <= base_cnt + 1'b1;
        end
      end
    end
  end
endmodule

// File: rtl/etc_fifo.sv
module etc_fifo #(
  parameter int WIDTH = 8,
  parameter int DEPTH = 16
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             push_i,
  input  logic [WIDTH-1:0] wdata_i,
  input  logic             pop_i,
  output logic [WIDTH-1:0] rdata_o,
  output logic             full_o,
  output logic             empty_o
);
  localparam int AW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam int CNTW = $clog2(DEPTH + 1);
  localparam logic [AW-1:0] PLAST = AW'(DEPTH - 1);

  logic [WIDTH-1:0] mem [DEPTH];
  logic [AW-1:0]    wptr_q, rptr_q;
  logic [CNTW-1:0]  count_q;
  logic             do_push, do_pop;

  assign full_o  = (count_q == CNTW'(DEPTH));
  assign empty_o = (count_q == '0);
  assign do_push = push_i && !full_o;
  assign do_pop  = pop_i && !empty_o;

  // Storage without reset so it maps to block RAM
  always_ff @(posedge clk) begin
    if (do_push) mem[wptr_q] <= wdata_i;
  end

  always_ff @(posedge clk) begin
    if (rst) rdata_o <= '0;
    else if (do_pop) rdata_o <= mem[rptr_q];
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      wptr_q  <= '0;
      rptr_q  <= '0;
      count_q <= '0;
    end else begin
      if (do_push) wptr_q <= (wptr_q == PLAST) ? '0 : wptr_q + 1'b1;
      if (do_pop)  rptr_q <= (rptr_q == PLAST) ? '0 : rptr_q + 1'b1;
      case ({do_push, do_pop})
        2'b10:   count_q <= count_q + 1'b1;
        2'b01:   count_q <= count_q - 1'b1;
        default: count_q <= count_q;
      endcase
    end
  end
endmodule

// File: rtl/entropy_tap_capture.sv
module entropy_tap_capture #(
  parameter  int N_CELLS    = 256,
  parameter  int DIV_RATIO  = 20,
  parameter  int BYTE_W     = 8,
  parameter  int FIFO_DEPTH = 16,
  localparam int IDX_W      = $clog2(N_CELLS)
) (
  input  logic               clk,
  input  logic               rst,
  input  logic [N_CELLS-1:0] cells_i,
  input  logic               cmd_valid_i,
  input  logic               cmd_mode_i,
  input  logic [IDX_W-1:0]   cmd_index_i,
  input  logic               rd_en_i,
  output logic               sample_bit_o,
  output logic               sample_valid_o,
  output logic [BYTE_W-1:0]  rd_data_o,
  output logic               fifo_empty_o,
  output logic               fifo_full_o,
  output logic               overflow_o
);
  logic              tick;
  logic              restart;
  logic [BYTE_W-1:0] packed_byte;
  logic              byte_push;

  etc_clk_div #(.DIV_RATIO(DIV_RATIO)) u_div (
    .clk    (clk),
    .rst    (rst),
    .tick_o (tick)
  );

  etc_tap_select #(.N_CELLS(N_CELLS)) u_tap (
    .clk         (clk),
    .rst         (rst),
    .tick_i      (tick),
    .cells_i     (cells_i),
    .cmd_valid_i (cmd_valid_i),
    .cmd_mode_i  (cmd_mode_i),
    .cmd_index_i (cmd_index_i),
    .bit_o       (sample_bit_o),
    .valid_o     (sample_valid_o),
    .restart_o   (restart)
  );

  etc_byte_packer #(.BYTE_W(BYTE_W)) u_pack (
    .clk       (clk),
    .rst       (rst),
    .bit_i     (sample_bit_o),
    .valid_i   (sample_valid_o),
    .restart_i (restart),
    .byte_o    (packed_byte),
    .push_o    (byte_push)
  );

  etc_fifo #(.WIDTH(BYTE_W), .DEPTH(FIFO_DEPTH)) u_fifo (
    .clk     (clk),
    .rst     (rst),
    .push_i  (byte_push),
    .wdata_i (packed_byte),
    .pop_i   (rd_en_i),
    .rdata_o (rd_data_o),
    .full_o  (fifo_full_o),
    .empty_o (fifo_empty_o)
  );

  always_ff @(posedge clk) begin
    if (rst) overflow_o <= 1'b0;
    else if (sample_valid_o && fifo_full_o) overflow_o <= 1'b1;
  end
endmodule

// File: rtl/etc_checker.sv
module etc_checker #(
  parameter int DIV_RATIO = 20,
  parameter int BYTE_W    = 8
) (
  input logic              clk,
  input logic              rst,
  input logic              sample_valid_o,
  input logic              rd_en_i,
  input logic [BYTE_W-1:0] rd_data_o,
  input logic              fifo_empty_o,
  input logic              fifo_full_o,
  input logic              overflow_o
);
  logic [31:0] gap_q;
  logic        seen_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      gap_q  <= '0;
      seen_q <= 1'b0;
    end else begin
      gap_q  <= sample_valid_o ? '0 : gap_q + 1'b1;
      if (sample_valid_o) seen_q <= 1'b1;
    end
  end

  // R2
  pulse_gap_chk: assert property (@(posedge clk) disable iff (rst)
    (sample_valid_o && seen_q) |-> (gap_q == 32'(DIV_RATIO - 1)));

  // R2
  pulse_due_chk: assert property (@(posedge clk) disable iff (rst)
    (seen_q && gap_q == 32'(DIV_RATIO - 1)) |-> sample_valid_o);

  // R8
  empty_read_chk: assert property (@(posedge clk) disable iff (rst)
    (rd_en_i && fifo_empty_o) |=> $stable(rd_data_o));

  // R9
  full_hold_chk: assert property (@(posedge clk) disable iff (rst)
    (fifo_full_o && !rd_en_i) |=> fifo_full_o);

  // R10
  overflow_sticky_chk: assert property (@(posedge clk) disable iff (rst)
    overflow_o |=> overflow_o);

  // R11
  flags_excl_chk: assert property (@(posedge clk) disable iff (rst)
    !(fifo_full_o && fifo_empty_o));
endmodule

bind entropy_tap_capture etc_checker #(
  .DIV_RATIO (DIV_RATIO),
  .BYTE_W    (BYTE_W)
) u_etc_chk (
  .clk            (clk),
  .rst            (rst),
  .sample_valid_o (sample_valid_o),
  .rd_en_i        (rd_en_i),
  .rd_data_o      (rd_data_o),
  .fifo_empty_o   (fifo_empty_o),
  .fifo_full_o    (fifo_full_o),
  .overflow_o     (overflow_o)
);

// File: tb/tb_entropy_tap_capture.sv
`timescale 1ns/1ps
module tb_entropy_tap_capture;
  localparam int N     = 16;
  localparam int DIV   = 4;
  localparam int DEPTH = 4;
  localparam int IW    = $clog2(N);

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic [N-1:0]  cells = '0;
  logic          cmd_valid = 1'b0;
  logic          cmd_mode = 1'b0;
  logic [IW-1:0] cmd_idx = '0;
  logic          rd_drain = 1'b0;
  logic          force_rd = 1'b0;
  logic          rd_en;
  logic          sample_bit, sample_valid, f_empty, f_full, ovf;
  logic [7:0]    rd_data;

  assign rd_en = rd_drain | force_rd;

  always #2.5 clk = ~clk;

  entropy_tap_capture #(
    .N_CELLS(N), .DIV_RATIO(DIV), .BYTE_W(8), .FIFO_DEPTH(DEPTH)
  ) dut (
    .clk(clk), .rst(rst), .cells_i(cells),
    .cmd_valid_i(cmd_valid), .cmd_mode_i(cmd_mode), .cmd_index_i(cmd_idx),
    .rd_en_i(rd_en), .sample_bit_o(sample_bit), .sample_valid_o(sample_valid),
    .rd_data_o(rd_data), .fifo_empty_o(f_empty), .fifo_full_o(f_full),
    .overflow_o(ovf)
  );

  int    n_checks = 0;
  int    n_fail   = 0;
  string cur_req  = "R1";
  int    pat      = 0;
  bit    drain_on = 1'b0;

  // model state
  logic [7:0]    exp_b [0:1023];
  int            exp_wr, rd_ptr, n_pops, cyc;
  bit            seen;
  logic          cm_mode, last_mode;
  logic [IW-1:0] cm_idx, last_idx;
  logic [7:0]    bsr, last_read;
  int            bcnt;
  logic [31:0]   rs = 32'h1234_5678;

  // values captured at the active edge
  logic          cap_rst = 1'b1, cap_cv = 1'b0, cap_cm = 1'b0, cap_pop = 1'b0;
  logic [IW-1:0] cap_ci = '0;
  logic [N-1:0]  cap_cells = '0;

  task automatic chk(input bit ok, input string req, input string what,
                     input int act, input int expv);
    n_checks++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, expv);
    end
  endtask

  always @(posedge clk) begin
    cap_rst   <= rst;
    cap_cells <= cells;
    cap_cv    <= cmd_valid;
    cap_cm    <= cmd_mode;
    cap_ci    <= cmd_idx;
    cap_pop   <= rd_en && !f_empty;
  end

  always @(negedge clk) begin
    logic eb;
    if (cap_rst) begin
      exp_wr = 0; rd_ptr = 0; n_pops = 0; cyc = 0; seen = 0;
      cm_mode = 0; cm_idx = '0; last_mode = 0; last_idx = '0;
      bsr = '0; bcnt = 0; last_read = '0;
    end else begin
      cyc++;
      if (cap_pop) begin
        // R6 R8 byte order and packing
        chk(rd_data === exp_b[rd_ptr & 1023], cur_req, "fifo byte",
            int'(rd_data), int'(exp_b[rd_ptr & 1023]));
        last_read = rd_data;
        rd_ptr++;
        n_pops++;
      end
      if (sample_valid) begin
        if (seen) chk(cyc == DIV, "R2", "sample spacing", cyc, DIV);
        cyc  = 0;
        seen = 1;
        eb = cm_mode ? cap_cells[cm_idx] : ^cap_cells;
        chk(sample_bit === eb, cur_req, "sample bit", int'(sample_bit), int'(eb));
        if (cm_mode != last_mode || cm_idx != last_idx) begin
          bsr = '0; bcnt = 0;
        end
        last_mode = cm_mode; last_idx = cm_idx;
        bsr = {bsr[6:0], eb};
        bcnt++;
        if (bcnt == 8) begin
          exp_b[exp_wr & 1023] = bsr;
          exp_wr++;
          bcnt = 0;
        end
      end
      if (cap_cv) begin
        cm_mode = cap_cm;
        cm_idx  = cap_ci;
      end
    end
    rs = rs ^ (rs << 13);
    rs = rs ^ (rs >> 17);
    rs = rs ^ (rs << 5);
    cells    = (pat == 1) ? '1 : rs[N-1:0];
    rd_drain = drain_on && !f_empty;
  end

  task automatic wait_cyc(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst = 1'b1;
    wait_cyc(3);
    rst = 1'b0;
  endtask

  task automatic write_cmd(input logic m, input logic [IW-1:0] i);
    @(negedge clk);
    cmd_valid = 1'b1; cmd_mode = m; cmd_idx = i;
    @(negedge clk);
    cmd_valid = 1'b0;
  endtask

  task automatic t_reset();
    cur_req = "R1";
    @(negedge clk);
    rst = 1'b1;
    wait_cyc(3);
    chk(f_empty == 1'b1, "R1", "empty", f_empty, 1);
    chk(f_full == 1'b0, "R1", "full", f_full, 0);
    chk(ovf == 1'b0, "R1", "overflow", ovf, 0);
    chk(sample_valid == 1'b0, "R1", "strobe", sample_valid, 0);
    chk(rd_data == 8'h00, "R1", "read data", rd_data, 0);
    rst = 1'b0;
    drain_on = 1'b1;
    wait_cyc(10 * DIV);
  endtask

  task automatic t_fold();
    cur_req = "R3";
    pat = 0;
    wait_cyc(40 * DIV);
    pat = 1;
    wait_cyc(12 * DIV);
    chk(sample_bit == 1'b0, "R3", "all-ones fold", sample_bit, 0);
    pat = 0;
  endtask

  task automatic t_single();
    cur_req = "R4";
    write_cmd(1'b1, '0);
    wait_cyc(24 * DIV);
    write_cmd(1'b1, IW'(N - 1));
    pat = 1;
    wait_cyc(12 * DIV);
    chk(sample_bit == 1'b1, "R4", "last index all ones", sample_bit, 1);
    pat = 0;
    wait_cyc(24 * DIV);
  endtask

  task automatic t_cmd_timing();
    cur_req = "R5";
    do @(negedge clk); while (!sample_valid);
    wait_cyc(DIV - 1);
    cmd_valid = 1'b1; cmd_mode = 1'b0; cmd_idx = '0;
    @(negedge clk);
    cmd_valid = 1'b0;
    chk(sample_valid == 1'b1, "R5", "write on capture edge", sample_valid, 1);
    wait_cyc(10 * DIV);
    write_cmd(1'b1, IW'(3));
    write_cmd(1'b1, IW'(5));
    wait_cyc(20 * DIV);
  endtask

  task automatic t_restart();
    cur_req = "R7";
    wait_cyc(3 * DIV);
    write_cmd(1'b1, IW'(9));
    wait_cyc(13 * DIV);
    write_cmd(1'b0, IW'(9));
    wait_cyc(5 * DIV);
    write_cmd(1'b0, IW'(9));
    wait_cyc(30 * DIV);
  endtask

  task automatic t_empty_read();
    int start;
    cur_req = "R8";
    start = n_pops;
    do @(negedge clk); while (!(n_pops > start && f_empty));
    drain_on = 1'b0;
    @(negedge clk);
    force_rd = 1'b1;
    @(negedge clk);
    force_rd = 1'b0;
    @(negedge clk);
    chk(rd_data == last_read, "R8", "read while empty", rd_data, last_read);
    drain_on = 1'b1;
    wait_cyc(8 * DIV);
  endtask

  task automatic t_overflow();
    cur_req = "R9";
    drain_on = 1'b0;
    do_reset();
    chk(ovf == 1'b0, "R10", "overflow after reset", ovf, 0);
    wait_cyc((DEPTH + 2) * 8 * DIV + 20);
    chk(f_full == 1'b1, "R9", "full", f_full, 1);
    chk(f_empty == 1'b0, "R11", "empty while full", f_empty, 0);
    chk(ovf == 1'b1, "R10", "overflow set", ovf, 1);
    @(negedge clk);
    force_rd = 1'b1;
    wait_cyc(DEPTH);
    force_rd = 1'b0;
    wait_cyc(2);
    chk(n_pops == DEPTH, "R9", "bytes kept", n_pops, DEPTH);
    chk(ovf == 1'b1, "R10", "overflow sticky", ovf, 1);
    do_reset();
    wait_cyc(1);
    chk(ovf == 1'b0, "R10", "overflow cleared", ovf, 0);
  endtask

  initial begin
    t_reset();
    t_fold();
    t_single();
    t_cmd_timing();
    t_restart();
    t_empty_read();
    chk(n_pops > 20, "R6", "bytes drained", n_pops, 21);
    t_overflow();
    $display("[TB] %0d tests run, %0d failed", n_checks, n_fail);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    n_checks++;
    n_fail++;
    $display("FAIL watchdog: actual timeout expected finish");
    $display("[TB] %0d tests run, %0d failed", n_checks, n_fail);
    $finish;
  end
endmodule